// File: doc/BRIEF.md
# Connection CAM Match Unit

This block is the connection lookup stage of a time-slot interchanger. A set of content-addressable banks (three by default) each hold a table of connection entries. An entry has four parts: a stream number, a time-slot number, a direction bit, and the data-memory address to use when the entry fires. It also has a valid flag.

On every clock a state counter presents the current stream, time slot and read/write phase. Each bank compares that key against all of its valid entries at the same time. When a bank finds a match, it raises a write request in the write phase or a read request in the read phase, toward the data memory. The request comes with the index of the matching entry and the stored target address. If several entries in one bank match, the entry with the lowest index wins. Nothing reports the conflict, and the entries are left as they are.

A host port writes one entry per clock, selected by bank and index. Clearing the valid flag through the same port removes a connection. Software keeps the table by writing entries. The surrounding switch uses the per-bank requests to move data between the bus and the data memory.

Top module: `conn_cam_match`

## Requirements
- R1: After reset, every entry is invalid and all requests are low. Every hit index and hit address output reads zero.
- R2: A host write stores stream, slot, direction, target address and valid flag into the selected bank and index. The new contents take part in compares from the next clock. A compare presented in the same cycle as the write still sees the old contents.
- R3: An entry matches only when it is valid and its stream, its slot and its direction bit all equal the state counter fields. The direction bit is 0 for the write phase and 1 for the read phase.
- R4: A match while the phase input is 0 raises that bank's write request one clock after the key is presented. The winning entry index and its stored address appear in the same cycle.
- R5: A match while the phase input is 1 raises that bank's read request one clock after the key is presented. The winning entry index and its stored address appear in the same cycle.
- R6: A bank with no match raises no request, and its hit index and hit address read zero.
- R7: With several matching entries in one bank, the lowest index is reported and no error indication exists. All entries remain unchanged, so the next-lowest match wins once the first is cleared.
- R8: Banks resolve independently. The same key stored in different banks produces a request from each, each with its own index and address.
- R9: An entry written with the valid flag at 0 never matches. Rewriting a matching entry as invalid stops its requests.
- R10: A bank never raises its write request and its read request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sc_stream | input | STREAM_W | State counter stream number |
| sc_slot | input | SLOT_W | State counter time-slot number |
| sc_rw | input | 1 | State counter phase, 0 write, 1 read |
| host_we | input | 1 | Host entry write strobe |
| host_bank | input | BANK_W | Bank selected by the host write |
| host_idx | input | IDX_W | Entry index selected by the host write |
| host_stream | input | STREAM_W | Stream comparand to store |
| host_slot | input | SLOT_W | Slot comparand to store |
| host_dir | input | 1 | Direction bit to store |
| host_addr | input | ADDR_W | Data-memory address to store |
| host_valid | input | 1 | Valid flag to store |
| wr_req | output | NUM_BANKS | Per-bank write request |
| rd_req | output | NUM_BANKS | Per-bank read request |
| hit_idx | output | NUM_BANKS*IDX_W | Per-bank winning entry index, bank 0 in the low bits |
| hit_addr | output | NUM_BANKS*ADDR_W | Per-bank winning target address, bank 0 in the low bits |

## Verification
The assertions rely on only two things about the inputs: the phase input is a defined 0 or 1 on every clock, and reset is held for at least one edge before any compare counts. They use nothing about table contents, so any host write sequence is allowed. The stimulus changes every input on the falling edge and keeps reset low for several cycles at the start. The bench samples outputs on the following falling edge, one register stage after the key is presented.

// File: rtl/conn_cam_pkg.sv
// Package: shared phase encoding for the connection CAM.
// Assumes: phase 0 means write into data memory, 1 means read out of it.
package conn_cam_pkg;
    typedef enum logic {
        PH_WRITE = 1'b0,
        PH_READ  = 1'b1
    } rw_phase_e;
endpackage

// File: rtl/cam_entry_array.sv
// Module: cam_entry_array
// Holds DEPTH connection entries of one bank and produces a match vector
// against the presented key. Host writes land at the clock edge, so a
// compare in the same cycle sees the previous contents.
// Assumes: synchronous active-low reset clears every valid flag.
module cam_entry_array #(
    parameter int DEPTH    = 16,
    parameter int STREAM_W = 5,
    parameter int SLOT_W   = 7,
    parameter int ADDR_W   = 10,
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [STREAM_W-1:0] wr_stream,
    input  logic [SLOT_W-1:0]   wr_slot,
    input  logic                wr_dir,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic                wr_valid,
    input  logic [STREAM_W-1:0] key_stream,
    input  logic [SLOT_W-1:0]   key_slot,
    input  logic                key_dir,
    output logic [DEPTH-1:0]    match_vec,
    output logic [ADDR_W-1:0]   addr_tab [DEPTH]
);
    logic [STREAM_W-1:0] stream_q [DEPTH];
    logic [SLOT_W-1:0]   slot_q   [DEPTH];
    logic [DEPTH-1:0]    dir_q;
    logic [DEPTH-1:0]    valid_q;
    logic [ADDR_W-1:0]   addr_q   [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        // Entry storage: load on a host write addressed to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stream_q[e] <= '0;
                slot_q[e]   <= '0;
                dir_q[e]    <= 1'b0;
                valid_q[e]  <= 1'b0;
                addr_q[e]   <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                stream_q[e] <= wr_stream;
                slot_q[e]   <= wr_slot;
                dir_q[e]    <= wr_dir;
                valid_q[e]  <= wr_valid;
                addr_q[e]   <= wr_addr;
            end
        end

        // Compare: a valid entry matches on stream, slot and direction.
        always_comb begin
            match_vec[e] = valid_q[e]
                         && (stream_q[e] == key_stream)
                         && (slot_q[e]   == key_slot)
                         && (dir_q[e]    == key_dir);
        end

        assign addr_tab[e] = addr_q[e];
    end
endmodule

// File: rtl/cam_lowest_first.sv
// Module: cam_lowest_first
// Priority resolver: returns whether any request bit is set and the index
// of the lowest set bit. Several set bits are not flagged.
// Assumes: nothing beyond a defined request vector.
module cam_lowest_first #(
    parameter int DEPTH  = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit is written last and wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/cam_bank.sv
// Module: cam_bank
// One CAM bank: entry table, lowest-index resolution and the registered
// request stage toward the data memory.
// Assumes: the key and phase are stable around the sampling edge.
module cam_bank
    import conn_cam_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int STREAM_W = 5,
    parameter int SLOT_W   = 7,
    parameter int ADDR_W   = 10,
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [STREAM_W-1:0] wr_stream,
    input  logic [SLOT_W-1:0]   wr_slot,
    input  logic                wr_dir,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic                wr_valid,
    input  logic [STREAM_W-1:0] key_stream,
    input  logic [SLOT_W-1:0]   key_slot,
    input  logic                key_rw,
    output logic                wreq,
    output logic                rreq,
    output logic [IDX_W-1:0]    win_idx,
    output logic [ADDR_W-1:0]   win_addr
);
    logic [DEPTH-1:0]  match_vec;
    logic [ADDR_W-1:0] addr_tab [DEPTH];
    logic              any_hit;
    logic [IDX_W-1:0]  sel_idx;
    rw_phase_e         phase;

    assign phase = rw_phase_e'(key_rw);

    cam_entry_array #(
        .DEPTH(DEPTH), .STREAM_W(STREAM_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_stream(wr_stream),
        .wr_slot(wr_slot), .wr_dir(wr_dir), .wr_addr(wr_addr),
        .wr_valid(wr_valid),
        .key_stream(key_stream), .key_slot(key_slot), .key_dir(key_rw),
        .match_vec(match_vec), .addr_tab(addr_tab)
    );

    cam_lowest_first #(.DEPTH(DEPTH)) u_prio (
        .req(match_vec), .any(any_hit), .idx(sel_idx)
    );

    // Request stage: register the winner and split by phase; zero on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wreq     <= 1'b0;
            rreq     <= 1'b0;
            win_idx  <= '0;
            win_addr <= '0;
        end else begin
            wreq     <= any_hit && (phase == PH_WRITE);
            rreq     <= any_hit && (phase == PH_READ);
            win_idx  <= any_hit ? sel_idx : '0;
            win_addr <= any_hit ? addr_tab[sel_idx] : '0;
        end
    end
endmodule

// File: rtl/conn_cam_match.sv
// Module: conn_cam_match (top)
// Parallel connection CAM banks for a time-slot interchanger. Every bank
// sees the same state counter key; the host port writes one entry per clock.
// Assumes: synchronous active-low reset; outputs are flattened per bank,
// bank 0 in the least significant field.
module conn_cam_match #(
    parameter int NUM_BANKS = 3,
    parameter int DEPTH     = 16,
    parameter int STREAM_W  = 5,
    parameter int SLOT_W    = 7,
    parameter int ADDR_W    = 10,
    localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [STREAM_W-1:0]           sc_stream,
    input  logic [SLOT_W-1:0]             sc_slot,
    input  logic                          sc_rw,
    input  logic                          host_we,
    input  logic [BANK_W-1:0]             host_bank,
    input  logic [IDX_W-1:0]              host_idx,
    input  logic [STREAM_W-1:0]           host_stream,
    input  logic [SLOT_W-1:0]             host_slot,
    input  logic                          host_dir,
    input  logic [ADDR_W-1:0]             host_addr,
    input  logic                          host_valid,
    output logic [NUM_BANKS-1:0]          wr_req,
    output logic [NUM_BANKS-1:0]          rd_req,
    output logic [NUM_BANKS*IDX_W-1:0]    hit_idx,
    output logic [NUM_BANKS*ADDR_W-1:0]   hit_addr
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_sel;

        // Bank decode: the host strobe reaches only the addressed bank.
        always_comb bank_sel = host_we && (host_bank == BANK_W'(b));

        cam_bank #(
            .DEPTH(DEPTH), .STREAM_W(STREAM_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .wr_en(bank_sel), .wr_idx(host_idx), .wr_stream(host_stream),
            .wr_slot(host_slot), .wr_dir(host_dir), .wr_addr(host_addr),
            .wr_valid(host_valid),
            .key_stream(sc_stream), .key_slot(sc_slot), .key_rw(sc_rw),
            .wreq(wr_req[b]), .rreq(rd_req[b]),
            .win_idx(hit_idx[b*IDX_W +: IDX_W]),
            .win_addr(hit_addr[b*ADDR_W +: ADDR_W])
        );
    end
endmodule

// File: rtl/conn_cam_match_chk.sv
// Module: conn_cam_match_chk
// Temporal checks on the request outputs, bound to conn_cam_match.
// Assumes: sc_rw is defined on every clock and reset is asserted first.
module conn_cam_match_chk #(
    parameter int NUM_BANKS = 3,
    parameter int IDX_W     = 4,
    parameter int ADDR_W    = 10
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        sc_rw,
    input logic [NUM_BANKS-1:0]        wr_req,
    input logic [NUM_BANKS-1:0]        rd_req,
    input logic [NUM_BANKS*IDX_W-1:0]  hit_idx,
    input logic [NUM_BANKS*ADDR_W-1:0] hit_addr
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        p_one_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_req[b] && rd_req[b]));

        p_wr_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
            wr_req[b] |-> ($past(sc_rw) == 1'b0));

        p_rd_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
            rd_req[b] |-> ($past(sc_rw) == 1'b1));

        p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_req[b] || rd_req[b]) |->
                (hit_idx[b*IDX_W +: IDX_W] == '0)
                && (hit_addr[b*ADDR_W +: ADDR_W] == '0));
    end
endmodule

bind conn_cam_match conn_cam_match_chk #(
    .NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sc_rw(sc_rw),
    .wr_req(wr_req), .rd_req(rd_req),
    .hit_idx(hit_idx), .hit_addr(hit_addr)
);

// File: tb/conn_cam_match_tb.sv
`timescale 1ns/1ps
module conn_cam_match_tb;
    localparam int NB = 3, DEPTH = 16, SW = 5, TW = 7, AW = 10;
    localparam int IW = 4, BW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [SW-1:0] sc_stream = '0;
    logic [TW-1:0] sc_slot = '0;
    logic sc_rw = 1'b0;
    logic host_we = 1'b0;
    logic [BW-1:0] host_bank = '0;
    logic [IW-1:0] host_idx = '0;
    logic [SW-1:0] host_stream = '0;
    logic [TW-1:0] host_slot = '0;
    logic host_dir = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic host_valid = 1'b0;
    logic [NB-1:0] wr_req, rd_req;
    logic [NB*IW-1:0] hit_idx;
    logic [NB*AW-1:0] hit_addr;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    conn_cam_match #(.NUM_BANKS(NB), .DEPTH(DEPTH), .STREAM_W(SW),
                     .SLOT_W(TW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sc_stream(sc_stream), .sc_slot(sc_slot),
        .sc_rw(sc_rw), .host_we(host_we), .host_bank(host_bank),
        .host_idx(host_idx), .host_stream(host_stream), .host_slot(host_slot),
        .host_dir(host_dir), .host_addr(host_addr), .host_valid(host_valid),
        .wr_req(wr_req), .rd_req(rd_req), .hit_idx(hit_idx), .hit_addr(hit_addr)
    );

    // One check of one bank's registered outputs.
    task automatic chk_bank(input int b, input logic ew, input logic er,
                            input int ei, input int ea, input string tag);
        logic aw_, ar_;
        int ai, aa;
        aw_ = wr_req[b]; ar_ = rd_req[b];
        ai = int'(hit_idx[b*IW +: IW]); aa = int'(hit_addr[b*AW +: AW]);
        checks++;
        if (aw_ !== ew || ar_ !== er || ai != ei || aa != ea) begin
            failures++;
            $display("FAIL %s bank%0d: got wr=%b rd=%b idx=%0d addr=%0h, expected wr=%b rd=%b idx=%0d addr=%0h",
                     tag, b, aw_, ar_, ai, aa, ew, er, ei, ea);
        end
    endtask

    task automatic host_wr(input int b, input int i, input int s, input int t,
                           input logic d, input int a, input logic v);
        @(negedge clk);
        host_we = 1'b1; host_bank = BW'(b); host_idx = IW'(i);
        host_stream = SW'(s); host_slot = TW'(t); host_dir = d;
        host_addr = AW'(a); host_valid = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // Present a key, then sample one register stage later.
    task automatic present(input int s, input int t, input logic rw);
        @(negedge clk);
        sc_stream = SW'(s); sc_slot = TW'(t); sc_rw = rw;
        @(negedge clk);
    endtask

    task automatic t_reset();
        present(0, 0, 1'b0);
        for (int b = 0; b < NB; b++) chk_bank(b, 0, 0, 0, 0, "R1 reset empty");
    endtask

    task automatic t_write_phase();
        host_wr(0, 5, 3, 10, 1'b0, 'h55, 1'b1);
        present(3, 10, 1'b0);
        chk_bank(0, 1, 0, 5, 'h55, "R4 write hit");
        chk_bank(1, 0, 0, 0, 0, "R6 other bank miss");
        present(3, 10, 1'b1);
        chk_bank(0, 0, 0, 0, 0, "R3 direction mismatch");
        present(3, 11, 1'b0);
        chk_bank(0, 0, 0, 0, 0, "R6 slot miss");
        present(2, 10, 1'b0);
        chk_bank(0, 0, 0, 0, 0, "R3 stream mismatch");
    endtask

    task automatic t_read_phase();
        host_wr(1, 2, 4, 33, 1'b1, 'h2a1, 1'b1);
        present(4, 33, 1'b1);
        chk_bank(1, 0, 1, 2, 'h2a1, "R5 read hit");
        chk_bank(0, 0, 0, 0, 0, "R10 bank0 quiet");
    endtask

    task automatic t_multi_hit();
        host_wr(2, 12, 7, 20, 1'b0, 'h0c0, 1'b1);
        host_wr(2, 9, 7, 20, 1'b0, 'h090, 1'b1);
        host_wr(2, 4, 7, 20, 1'b0, 'h040, 1'b1);
        present(7, 20, 1'b0);
        chk_bank(2, 1, 0, 4, 'h040, "R7 lowest wins");
        host_wr(2, 4, 7, 20, 1'b0, 'h040, 1'b0);
        present(7, 20, 1'b0);
        chk_bank(2, 1, 0, 9, 'h090, "R7 next lowest, entry intact");
        present(7, 20, 1'b0);
        chk_bank(2, 1, 0, 9, 'h090, "R7 repeat unchanged");
    endtask

    task automatic t_banks();
        host_wr(0, 1, 1, 1, 1'b1, 'h101, 1'b1);
        host_wr(1, 15, 1, 1, 1'b1, 'h3ff, 1'b1);
        present(1, 1, 1'b1);
        chk_bank(0, 0, 1, 1, 'h101, "R8 bank0");
        chk_bank(1, 0, 1, 15, 'h3ff, "R8 bank1");
        chk_bank(2, 0, 0, 0, 0, "R8 bank2 empty");
    endtask

    task automatic t_invalid();
        host_wr(0, 7, 9, 9, 1'b0, 'h077, 1'b0);
        present(9, 9, 1'b0);
        chk_bank(0, 0, 0, 0, 0, "R9 invalid never matches");
        host_wr(0, 1, 1, 1, 1'b1, 'h101, 1'b0);
        present(1, 1, 1'b1);
        chk_bank(0, 0, 0, 0, 0, "R9 cleared entry");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        sc_stream = SW'(12); sc_slot = TW'(64); sc_rw = 1'b1;
        host_we = 1'b1; host_bank = BW'(1); host_idx = IW'(0);
        host_stream = SW'(12); host_slot = TW'(64); host_dir = 1'b1;
        host_addr = AW'('h1e0); host_valid = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        chk_bank(1, 0, 0, 0, 0, "R2 old contents in write cycle");
        @(negedge clk);
        chk_bank(1, 0, 1, 0, 'h1e0, "R2 new entry next clock");
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_write_phase();
                t_read_phase();
                t_multi_hit();
                t_banks();
                t_invalid();
                t_same_cycle();
            end
            begin
                repeat (20000) @(posedge clk);
                failures++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule